// File: doc/BRIEF.md
# H-Bridge Winding Current Chopper

This block runs one H-bridge through a fixed-frequency current-chopping cycle. A period counter, clocked by the system clock, restarts every PWM period. At each restart the bridge drives the winding in the polarity that the phase bit selects. Drive continues until a sampled current-trip flag reports that the winding current has reached its limit. The trip flag is not looked at during a blanking window at the start of drive. Once drive ends, the bridge spends the rest of the period in a decay state, and a decay-select bit picks which one. Braking recirculates the current through both low-side FETs. Mixed decay first reverses the bridge and then changes to braking at three quarters of the period. If a zero-current flag arrives during the reversed phase, the bridge is turned fully off.

The chopper also converts a 3-bit current code into a percentage of full scale, which sets an external reference DAC. Every change of gate state passes through a break-before-make sequencer. A synchronous halt input turns all gates off in the same cycle and restarts the period when it is released.

Top module: `winding_chopper`

## Requirements
- R1: With `bridge_en`=1 during drive, the gate vector {`hs1`,`ls1`,`hs2`,`ls2`} is 1001 when `dir_phase`=1 and 0110 when `dir_phase`=0.
- R2: When `bridge_en` is 0 the FSM goes idle on the next edge and all gates are off one edge later. They stay off through later period starts for as long as `bridge_en` stays 0.
- R3: The period is CLK_HZ/50 kHz cycles, which is 2000 at 100 MHz. With HIGH_RATE=1 it is CLK_HZ/100 kHz. Drive restarts at every period start whether or not the trip flag fired, and it holds through a period in which no trip occurs.
- R4: After drive begins, `trip_flag` is ignored for BLANK_NS of clock time, which is 375 cycles by default. Drive therefore lasts at least that long.
- R5: With `decay_mixed`=0, a trip after blanking leads to braking (gate vector 0101), which lasts until the next period start.
- R6: With `decay_mixed`=1, a trip after blanking leads to reverse drive (1001 for `dir_phase`=0, 0110 for `dir_phase`=1). From counter value 3/4 of the period onward (1500 by default) the bridge brakes with 0101.
- R7: During reverse drive, `zero_flag`=1 turns all gates off. Braking still begins at the 3/4 point.
- R8: `ref_pct` is 20, 38, 56, 71, 83, 92, 98 or 100 for `cur_code` 0 through 7.
- R9: A high-side and a low-side FET on the same leg are never on together. After any gate turns off, no gate turns on for at least DEAD_CYC cycles, which is 4 by default.
- R10: `halt`=1 forces all gates off in the same cycle. On release the period counter restarts from zero, and the gates stay off for DEAD_CYC cycles before drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt | input | 1 | Global disable, synchronous to clk |
| bridge_en | input | 1 | Allows current in the bridge |
| dir_phase | input | 1 | Drive polarity |
| cur_code | input | 3 | Relative current code |
| decay_mixed | input | 1 | 0 selects braking decay, 1 selects mixed decay |
| trip_flag | input | 1 | Sampled current-limit comparator |
| zero_flag | input | 1 | Sampled zero-current detector |
| hs1 | output | 1 | High-side gate, leg 1 |
| ls1 | output | 1 | Low-side gate, leg 1 |
| hs2 | output | 1 | High-side gate, leg 2 |
| ls2 | output | 1 | Low-side gate, leg 2 |
| ref_pct | output | 7 | Reference level in percent of full scale |

## Verification
The assertions assume that every control and flag input is already synchronous to `clk` and holds steady across each rising edge. They also assume that `trip_flag` and `zero_flag` are single-bit samples with no metastability, and that `halt` is a registered signal rather than an asynchronous pin. The stimulus changes inputs only on falling clock edges. Each scenario starts from a halt pulse, so every expectation can be counted in cycles from a known period start. The zero-current flag is raised only while the bridge is in reverse drive.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DRIVE = 3'd1,
    ST_FAST  = 3'd2,
    ST_OFF   = 3'd3,
    ST_SLOW  = 3'd4
  } chop_st_e;

  // percent of full scale for each current code
  function automatic logic [6:0] code_to_pct(input logic [2:0] code);
    logic [6:0] p;
    case (code)
      3'd0:    p = 7'd20;
      3'd1:    p = 7'd38;
      3'd2:    p = 7'd56;
      3'd3:    p = 7'd71;
      3'd4:    p = 7'd83;
      3'd5:    p = 7'd92;
      3'd6:    p = 7'd98;
      default: p = 7'd100;
    endcase
    return p;
  endfunction

  // gate vector {hs1, ls1, hs2, ls2} for a state and polarity
  function automatic logic [3:0] gates_for(input chop_st_e st, input logic ph);
    logic [3:0] g;
    case (st)
      ST_DRIVE: g = ph ? 4'b1001 : 4'b0110;
      ST_FAST:  g = ph ? 4'b0110 : 4'b1001;
      ST_SLOW:  g = 4'b0101;
      default:  g = 4'b0000;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/chop_period_timer.sv
module chop_period_timer #(
  parameter int PERIOD_CYC = 2000,
  parameter int CW         = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST_T = CW'(PERIOD_CYC - 1);

  logic period_wrap;
  assign period_wrap = (cnt == LAST_T);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (halt)        cnt <= '0;
    else if (period_wrap) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_T);

  a_r3_wraps_to_zero: assert property (@(posedge clk) disable iff (!rst_n || halt)
    (cnt == LAST_T) |=> (cnt == '0));

  a_r10_halt_restart: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (cnt == '0));

endmodule

// File: rtl/chop_phase_fsm.sv
module chop_phase_fsm
  import chop_pkg::*;
#(
  parameter int PERIOD_CYC = 2000,
  parameter int BLANK_CYC  = 375,
  parameter int MIX_CYC    = 1500,
  parameter int CW         = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt,
  input  logic [CW-1:0] cnt,
  input  logic          en,
  input  logic          mixed,
  input  logic          trip,
  input  logic          zero,
  output chop_st_e      st,
  output logic          sense_open
);
  localparam logic [CW-1:0] BLANK_T  = CW'(BLANK_CYC);
  localparam logic [CW-1:0] MIX_LAST = CW'(MIX_CYC - 1);
  localparam logic [CW-1:0] LAST_T   = CW'(PERIOD_CYC - 1);

  logic period_start, mix_point, trip_seen;
  assign period_start = (cnt == '0);
  assign mix_point    = (cnt == MIX_LAST);
  assign sense_open   = (cnt >= BLANK_T);
  assign trip_seen    = sense_open && trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
    end else if (halt || !en) begin
      st <= ST_IDLE;
    end else if (period_start) begin
      st <= ST_DRIVE;
    end else begin
      case (st)
        ST_DRIVE: if (trip_seen) begin
          if (!mixed)               st <= ST_SLOW;
          else if (cnt >= MIX_LAST) st <= ST_SLOW;
          else                      st <= ST_FAST;
        end
        ST_FAST:  if (mix_point) st <= ST_SLOW;
                  else if (zero) st <= ST_OFF;
        ST_OFF:   if (mix_point) st <= ST_SLOW;
        default:  st <= st;
      endcase
    end
  end

  a_r4_blank_hold: assert property (@(posedge clk) disable iff (!rst_n || halt || !en)
    (st == ST_DRIVE && cnt != '0 && cnt < BLANK_T) |=> (st == ST_DRIVE));

  a_r5_slow_hold: assert property (@(posedge clk) disable iff (!rst_n || halt || !en)
    (st == ST_SLOW && cnt != '0 && cnt != LAST_T) |=> (st == ST_SLOW));

  a_r6_fast_window: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FAST) |-> (cnt <= MIX_LAST));

  a_r7_zero_stops: assert property (@(posedge clk) disable iff (!rst_n || halt || !en)
    (st == ST_FAST && zero && !mix_point && cnt != '0) |=> (st == ST_OFF));

  a_r2_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (st == ST_IDLE));

endmodule

// File: rtl/chop_gate_seq.sv
module chop_gate_seq #(
  parameter int DEAD_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt,
  input  logic [3:0] tgt,
  output logic [3:0] gate,
  output logic       dead_busy
);
  localparam int DW = $clog2(DEAD_CYC + 2);
  localparam logic [DW-1:0] DEAD_T = DW'(DEAD_CYC);

  logic [3:0]    gate_q;
  logic [DW-1:0] dc;
  logic          must_drop;

  assign must_drop = |(gate_q & ~tgt);
  assign dead_busy = (dc != '0);
  assign gate      = gate_q & {4{~halt}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
      dc     <= '0;
    end else if (halt) begin
      gate_q <= '0;
      dc     <= DEAD_T;
    end else if (must_drop) begin
      gate_q <= gate_q & tgt;
      dc     <= DEAD_T;
    end else if (dead_busy) begin
      dc     <= dc - 1'b1;
    end else begin
      gate_q <= tgt;
    end
  end

  a_r9_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate[3] && gate[2]) && !(gate[1] && gate[0]));

  a_r9_no_on_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
    dead_busy |=> ((gate_q & ~$past(gate_q)) == 4'b0000));

endmodule

// File: rtl/winding_chopper.sv
module winding_chopper
  import chop_pkg::*;
#(
  parameter int CLK_HZ    = 100_000_000,
  parameter bit HIGH_RATE = 1'b0,
  parameter int BLANK_NS  = 3750,
  parameter int DEAD_CYC  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt,
  input  logic       bridge_en,
  input  logic       dir_phase,
  input  logic [2:0] cur_code,
  input  logic       decay_mixed,
  input  logic       trip_flag,
  input  logic       zero_flag,
  output logic       hs1,
  output logic       ls1,
  output logic       hs2,
  output logic       ls2,
  output logic [6:0] ref_pct
);
  localparam longint PWM_HZ     = HIGH_RATE ? 64'd100_000 : 64'd50_000;
  localparam int     PERIOD_CYC = int'(longint'(CLK_HZ) / PWM_HZ);
  localparam int     BLANK_CYC  = int'((longint'(CLK_HZ) * longint'(BLANK_NS)) / 64'd1_000_000_000);
  localparam int     MIX_CYC    = (PERIOD_CYC * 3) / 4;
  localparam int     CW         = $clog2(PERIOD_CYC);

  logic [CW-1:0] cnt;
  chop_st_e      st;
  logic          sense_open;
  logic [3:0]    tgt, gate;
  logic          dead_busy;

  chop_period_timer #(.PERIOD_CYC(PERIOD_CYC), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .halt(halt), .cnt(cnt)
  );

  chop_phase_fsm #(
    .PERIOD_CYC(PERIOD_CYC), .BLANK_CYC(BLANK_CYC), .MIX_CYC(MIX_CYC), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .halt(halt), .cnt(cnt), .en(bridge_en),
    .mixed(decay_mixed), .trip(trip_flag), .zero(zero_flag),
    .st(st), .sense_open(sense_open)
  );

  assign tgt = gates_for(st, dir_phase);

  chop_gate_seq #(.DEAD_CYC(DEAD_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .halt(halt), .tgt(tgt),
    .gate(gate), .dead_busy(dead_busy)
  );

  assign {hs1, ls1, hs2, ls2} = gate;
  assign ref_pct = code_to_pct(cur_code);

  a_r10_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt) |-> ({hs1, ls1, hs2, ls2} == 4'b0000));

  a_r8_pct_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pct >= 7'd20) && (ref_pct <= 7'd100));

endmodule

// File: tb/sim_winding_chopper.sv
module sim_winding_chopper;

  typedef struct {
    int         at;
    logic [3:0] g;
    logic [2:0] code;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt = 1'b1;
  logic       bridge_en = 1'b0;
  logic       dir_phase = 1'b0;
  logic [2:0] cur_code = 3'd0;
  logic       decay_mixed = 1'b0;
  logic       trip_flag = 1'b0;
  logic       zero_flag = 1'b0;
  logic       hs1, ls1, hs2, ls2;
  logic [6:0] ref_pct;

  int   cyc = 0;
  int   base = 0;
  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;
  exp_t q[$];

  int pct_tbl [8] = '{20, 38, 56, 71, 83, 92, 98, 100};

  always #5 clk = ~clk;

  winding_chopper u0 (
    .clk(clk), .rst_n(rst_n), .halt(halt), .bridge_en(bridge_en),
    .dir_phase(dir_phase), .cur_code(cur_code), .decay_mixed(decay_mixed),
    .trip_flag(trip_flag), .zero_flag(zero_flag),
    .hs1(hs1), .ls1(ls1), .hs2(hs2), .ls2(ls2), .ref_pct(ref_pct)
  );

  // expected gate vectors {hs1, ls1, hs2, ls2}
  function automatic logic [3:0] drv_vec(input logic ph);
    return ph ? 4'b1001 : 4'b0110;
  endfunction
  function automatic logic [3:0] rev_vec(input logic ph);
    return drv_vec(!ph);
  endfunction
  localparam logic [3:0] BRAKE = 4'b0101;
  localparam logic [3:0] NONE  = 4'b0000;

  task automatic push_abs(input int at, input logic [3:0] g, input logic [2:0] c, input string tag);
    exp_t e;
    e.at = at; e.g = g; e.code = c; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic push_rel(input int k, input logic [3:0] g, input string tag);
    push_abs(base + 1 + k, g, cur_code, tag);
  endtask

  task automatic wait_rel(input int k);
    while (cyc < base + k) @(negedge clk);
  endtask

  task automatic start_run(input logic ph, input logic mix, input logic [2:0] c, input logic tr);
    @(negedge clk);
    halt = 1'b1; bridge_en = 1'b1; dir_phase = ph; decay_mixed = mix;
    cur_code = c; trip_flag = tr; zero_flag = 1'b0;
    @(negedge clk);
    halt = 1'b0;
    base = cyc;
  endtask

  // monitor: compares scoreboard items 2 ns after each rising edge
  always begin
    @(posedge clk);
    cyc = cyc + 1;
    #2;
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.at != cyc) begin
        errors++;
        $display("FAIL %s: item due at %0d not sampled (now %0d)", e.tag, e.at, cyc);
      end else if ({hs1, ls1, hs2, ls2} !== e.g || ref_pct !== 7'(pct_tbl[e.code])) begin
        errors++;
        $display("FAIL %s: cycle %0d gates %b pct %0d, expected gates %b pct %0d",
                 e.tag, cyc, {hs1, ls1, hs2, ls2}, ref_pct, e.g, pct_tbl[e.code]);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      if (q.size() > 0) begin
        checks += q.size();
        errors += q.size();
        $display("FAIL pending: %0d scoreboard items never sampled, expected 0", q.size());
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run still active at cycle %0d, expected finish", cyc);
    finish_run();
  end

  initial begin
    // reset state, halted
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push_abs(cyc + 1, NONE, cur_code, "R10 reset gates off");

    // R8: reference percentage for every code
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      cur_code = 3'(c);
      push_abs(cyc + 1, NONE, 3'(c), "R8 code to percent");
    end

    // A: phase 1, braking decay, trip held from the start
    start_run(1'b1, 1'b0, 3'd7, 1'b1);
    push_rel(3,    NONE,          "R10 gap after release");
    push_rel(4,    drv_vec(1'b1), "R1 drive phase 1");
    push_rel(370,  drv_vec(1'b1), "R4 trip ignored in blanking");
    push_rel(376,  4'b0001,       "R9 high side dropped first");
    push_rel(380,  4'b0001,       "R9 dead time held");
    push_rel(381,  BRAKE,         "R5 braking after trip");
    push_rel(1990, BRAKE,         "R5 braking until period end");
    push_rel(2001, 4'b0001,       "R3 new period leaves brake");
    push_rel(2006, drv_vec(1'b1), "R3 drive at period 2000");
    push_rel(2800, drv_vec(1'b1), "R3 drive holds without trip");
    push_rel(4100, drv_vec(1'b1), "R3 drive across period start");
    wait_rel(1991);
    trip_flag = 1'b0;
    wait_rel(4101);

    // B: phase 0, mixed decay
    start_run(1'b0, 1'b1, 3'd2, 1'b1);
    push_rel(4,    drv_vec(1'b0), "R1 drive phase 0");
    push_rel(376,  NONE,          "R9 both legs off before reverse");
    push_rel(380,  NONE,          "R6 dead time before reverse");
    push_rel(381,  rev_vec(1'b0), "R6 reverse drive");
    push_rel(1499, rev_vec(1'b0), "R6 reverse until 3/4 point");
    push_rel(1500, 4'b0001,       "R6 reverse high side dropped");
    push_rel(1505, BRAKE,         "R6 braking after 3/4 point");
    wait_rel(1506);

    // C: phase 1, mixed decay, zero current, then enable low
    start_run(1'b1, 1'b1, 3'd0, 1'b1);
    push_rel(381,  rev_vec(1'b1), "R6 reverse drive phase 1");
    push_rel(801,  NONE,          "R7 off at zero current");
    push_rel(1499, NONE,          "R7 off until 3/4 point");
    push_rel(1500, BRAKE,         "R7 braking at 3/4 point");
    push_rel(1601, BRAKE,         "R2 gates before enable drop");
    push_rel(1602, NONE,          "R2 enable low gates off");
    push_rel(2010, NONE,          "R2 no drive at period start");
    push_rel(2100, NONE,          "R2 stays off");
    wait_rel(800);
    zero_flag = 1'b1;
    wait_rel(1601);
    bridge_en = 1'b0;
    wait_rel(2101);

    // D: halt during drive, then release
    start_run(1'b1, 1'b0, 3'd5, 1'b0);
    push_rel(4,    drv_vec(1'b1), "R1 drive before halt");
    push_rel(999,  drv_vec(1'b1), "R10 drive until halt");
    push_rel(1000, NONE,          "R10 halt gates off");
    push_rel(1200, NONE,          "R10 halt holds off");
    push_rel(1300 + 3, NONE,          "R10 release gap");
    push_rel(1300 + 4, drv_vec(1'b1), "R10 drive after release");
    wait_rel(1000);
    halt = 1'b1;
    wait_rel(1300);
    halt = 1'b0;
    wait_rel(1306);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule